// File: doc/BRIEF.md
# Four-Phase Handshake Word Synchronizer

This block carries one data word at a time from a transmit clock domain to a receive clock domain whose clock is not related to the first. The transmitting logic offers a word with `tx_start`. The block copies the word into a holding register, and that register keeps its value for the whole transfer. Only two single-bit flags cross between the domains: a request goes toward the receiver and an acknowledge comes back. Each flag passes through a flip-flop chain whose depth is a parameter from 2 to 10, with 4 as the default. The data width is also a parameter, and it defaults to 32 bits.

On the receive side the word shows up on `rx_data` together with `rx_strobe`. With `EXT_ACK = 0` the block acknowledges the word by itself, so `rx_strobe` acts as a one-cycle valid pulse with no back-pressure. With `EXT_ACK = 1` the receiving logic holds off the acknowledge until it raises `rx_ack`. In that mode `rx_strobe` stays high as a valid flag until the acknowledge has travelled through the transmit side and the request has dropped. This gives the receiver back-pressure over a handshake of any length.

On the transmit side, `tx_taken` is the closing half of the handshake. `tx_start` may be raised only while `tx_taken` is low. It must then stay high until `tx_taken` rises. Once `tx_taken` falls again, the next word may be offered. `rx_data`, `rx_strobe` and `tx_taken` all come directly from flip-flops. Each domain has its own synchronous, active-high reset.

Top module: `hs_bus_sync`

## Requirements
- R1: Every word accepted on the transmit side appears on `rx_data` exactly once and bit-for-bit unchanged, for any clock ratio.
- R2: A word is captured from `tx_data` on the `tx_clk` edge where `tx_start` is high, `tx_taken` is low and no transfer is in flight. Changes to `tx_data` after that edge have no effect on the delivered word.
- R3: `tx_taken` rises only after the receive side has presented the word. It falls only after the request and acknowledge have both returned low. A new word is accepted only after it has fallen.
- R4: With `EXT_ACK = 0`, `rx_strobe` is high for exactly one `rx_clk` cycle per word, in the cycle where `rx_data` holds that word. `rx_ack` is ignored.
- R5: With `EXT_ACK = 1`, `rx_strobe` rises with the new word and stays high, with `rx_data` constant, until `rx_ack` has been seen and the request has dropped.
- R6: With `EXT_ACK = 1`, `rx_ack` held high while `rx_strobe` is low has no effect: no strobe appears and `tx_taken` stays low.
- R7: While its reset is high, each domain clears its outputs to zero. `rx_data`, `rx_strobe` and `tx_taken` read 0 after reset.
- R8: Between strobes, `rx_data` keeps the last delivered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit-domain clock |
| tx_rst | input | 1 | Synchronous active-high reset, transmit domain |
| tx_data | input | WIDTH | Word to be sent |
| tx_start | input | 1 | Offers `tx_data`; held high until `tx_taken` rises |
| tx_taken | output | 1 | Receive side has the word; low again when the handshake ends |
| rx_clk | input | 1 | Receive-domain clock |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| rx_data | output | WIDTH | Delivered word, registered |
| rx_strobe | output | 1 | New word on `rx_data` (pulse or held, by mode) |
| rx_ack | input | 1 | Receiver acknowledge, used only when `EXT_ACK = 1` |

## Verification
The embedded assertions check, on every cycle, the local rules of the handshake. They cover the one-cycle strobe in internal mode, the held strobe and stable data in external mode, and a stable holding register while a transfer is in flight. They also check that acceptance happens only when the transmit side is free, and that the acknowledge and `tx_taken` rise only after a request. Whether every word arrives exactly once and unchanged depends on how the two clocks interleave. Only the bench scenarios can show that, by running a scoreboard under both slow-to-fast and fast-to-slow ratios. The same applies to the absence of effect from idle acknowledges and to the ordering of `tx_taken` against delivery.

// File: rtl/hs_sync_pkg.sv
package hs_sync_pkg;
  localparam int unsigned SYNC_MIN = 2;
  localparam int unsigned SYNC_MAX = 10;

  typedef enum logic [1:0] {
    RX_IDLE     = 2'd0,
    RX_WAIT_ACK = 2'd1,
    RX_RETURN   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/hs_bit_sync.sv
module hs_bit_sync #(
  parameter int unsigned STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_tx_side.sv
module hs_tx_side #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             tx_start,
  input  logic             ack_sync,
  output logic             tx_taken,
  output logic             req,
  output logic [WIDTH-1:0] hold
);
  logic accept;

  assign accept = tx_start && !req && !tx_taken && !ack_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      tx_taken <= 1'b0;
      hold     <= '0;
    end else begin
      tx_taken <= ack_sync;
      if (accept) begin
        hold <= tx_data;
        req  <= 1'b1;
      end else if (ack_sync) begin
        req  <= 1'b0;
      end
    end
  end

  AST_ACCEPT_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> !$past(tx_taken)) else $error("accept while busy"); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (req || tx_taken) |=> $stable(hold)) else $error("hold changed in flight"); // R2
  AST_TAKEN_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_taken) |-> $past(req)) else $error("taken without request"); // R3
endmodule

// File: rtl/hs_rx_side.sv
module hs_rx_side
  import hs_sync_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter bit          EXT_ACK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_sync,
  input  logic [WIDTH-1:0] hold,
  input  logic             rx_ack,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_strobe,
  output logic             ack
);
  rx_state_e state;
  logic      ack_go;

  generate
    if (EXT_ACK) begin : g_ext
      assign ack_go = rx_ack;
    end else begin : g_int
      assign ack_go = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      rx_strobe <= 1'b0;
      ack       <= 1'b0;
      rx_data   <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (req_sync) begin
            rx_data   <= hold;
            rx_strobe <= 1'b1;
            if (EXT_ACK) begin
              state <= RX_WAIT_ACK;
            end else begin
              ack   <= 1'b1;
              state <= RX_RETURN;
            end
          end
        end
        RX_WAIT_ACK: begin
          if (ack_go) begin
            ack   <= 1'b1;
            state <= RX_RETURN;
          end
        end
        RX_RETURN: begin
          if (!EXT_ACK) rx_strobe <= 1'b0;
          if (!req_sync) begin
            ack       <= 1'b0;
            rx_strobe <= 1'b0;
            state     <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  generate
    if (EXT_ACK) begin : g_chk_ext
      AST_STROBE_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_strobe && !ack) |=> rx_strobe) else $error("strobe dropped early"); // R5
    end else begin : g_chk_int
      AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> !rx_strobe) else $error("strobe longer than one cycle"); // R4
    end
  endgenerate

  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> (!rx_strobe || $stable(rx_data))) else $error("data moved under strobe"); // R5
  AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> req_sync) else $error("ack without request"); // R3
endmodule

// File: rtl/hs_bus_sync.sv
module hs_bus_sync
  import hs_sync_pkg::*;
#(
  parameter int unsigned WIDTH      = 32,
  parameter int unsigned S2D_STAGES = 4,
  parameter int unsigned D2S_STAGES = 4,
  parameter bit          EXT_ACK    = 1'b0
) (
  input  logic             tx_clk,
  input  logic             tx_rst,
  input  logic [WIDTH-1:0] tx_data,
  input  logic             tx_start,
  output logic             tx_taken,
  input  logic             rx_clk,
  input  logic             rx_rst,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_strobe,
  input  logic             rx_ack
);
  logic             req;
  logic             req_sync;
  logic             ack;
  logic             ack_sync;
  logic [WIDTH-1:0] hold;

  initial begin
    AST_STAGE_RANGE: assert (S2D_STAGES >= SYNC_MIN && S2D_STAGES <= SYNC_MAX &&
                             D2S_STAGES >= SYNC_MIN && D2S_STAGES <= SYNC_MAX)
      else $error("synchronizer depth out of range"); // R1
  end

  hs_tx_side #(.WIDTH(WIDTH)) u_tx (
    .clk(tx_clk), .rst(tx_rst), .tx_data(tx_data), .tx_start(tx_start),
    .ack_sync(ack_sync), .tx_taken(tx_taken), .req(req), .hold(hold)
  );

  hs_bit_sync #(.STAGES(S2D_STAGES)) u_req_sync (
    .clk(rx_clk), .rst(rx_rst), .d(req), .q(req_sync)
  );

  hs_bit_sync #(.STAGES(D2S_STAGES)) u_ack_sync (
    .clk(tx_clk), .rst(tx_rst), .d(ack), .q(ack_sync)
  );

  hs_rx_side #(.WIDTH(WIDTH), .EXT_ACK(EXT_ACK)) u_rx (
    .clk(rx_clk), .rst(rx_rst), .req_sync(req_sync), .hold(hold),
    .rx_ack(rx_ack), .rx_data(rx_data), .rx_strobe(rx_strobe), .ack(ack)
  );
endmodule

// File: tb/sim_hs_bus_sync.sv
module sim_hs_bus_sync;
  localparam int W = 32;
  localparam int N = 24;

  logic tx_clk = 0, rx_clk = 0, tx_rst = 1, rx_rst = 1;
  int   rx_half = 13;
  always #5 tx_clk = ~tx_clk;
  always #(rx_half) rx_clk = ~rx_clk;

  logic [W-1:0] d0 = '0, d1 = '0, o0, o1;
  logic s0 = 0, s1 = 0, t0, t1, k0, k1;
  logic a0 = 1'b1;  // internal mode: ack held high, must be ignored (R4)
  logic a1 = 1'b0;

  hs_bus_sync #(.WIDTH(W), .EXT_ACK(1'b0)) u0 (
    .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_data(d0), .tx_start(s0), .tx_taken(t0),
    .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_data(o0), .rx_strobe(k0), .rx_ack(a0));
  hs_bus_sync #(.WIDTH(W), .EXT_ACK(1'b1)) u1 (
    .tx_clk(tx_clk), .tx_rst(tx_rst), .tx_data(d1), .tx_start(s1), .tx_taken(t1),
    .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_data(o1), .rx_strobe(k1), .rx_ack(a1));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [W-1:0] q0[$], q1[$];
  int sent0 = 0, sent1 = 0, got0 = 0, got1 = 0;
  logic [W-1:0] last0 = '0, last1 = '0;
  bit pk0 = 0, pk1 = 0, pt0 = 0, pt1 = 0, ack_given = 0, mon_on = 0;
  int ack_wait = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // receive-side reference: scoreboard and per-cycle protocol model
  always @(negedge rx_clk) begin
    if (mon_on && !rx_rst) begin
      if (k0) begin
        chk(!pk0, "R4", "strobe width", 2, 1);
        if (q0.size() > 0) begin
          chk(o0 == q0[0], "R1", "word int", o0, q0[0]);
          last0 = q0.pop_front();
        end else chk(0, "R1", "extra word int", o0, 0);
        got0++;
      end else chk(o0 == last0, "R8", "retain int", o0, last0);
      if (k1 && !pk1) begin
        if (q1.size() > 0) begin
          chk(o1 == q1[0], "R1", "word ext", o1, q1[0]);
          last1 = q1.pop_front();
        end else chk(0, "R1", "extra word ext", o1, 0);
        got1++;
        ack_given = 0;
        ack_wait = got1 % 4;
      end else if (k1) begin
        chk(o1 == last1, "R5", "data under strobe", o1, last1);
      end else begin
        chk(o1 == last1, "R8", "retain ext", o1, last1);
        if (pk1) chk(ack_given, "R5", "strobe fell before ack", 0, 1);
      end
      pk0 = k0;
      pk1 = k1;
      // external acknowledge driver with varying delay
      if (k1 && !a1) begin
        if (ack_wait == 0) begin a1 = 1; ack_given = 1; end
        else ack_wait--;
      end else if (!k1) a1 = 0;
    end
  end

  // transmit-side: taken must follow delivery
  always @(negedge tx_clk) begin
    if (mon_on && !tx_rst) begin
      if (t0 && !pt0) chk(got0 == sent0, "R3", "taken before delivery int", got0, sent0);
      if (t1 && !pt1) chk(got1 == sent1, "R3", "taken before delivery ext", got1, sent1);
      pt0 = t0;
      pt1 = t1;
    end
  end

  task automatic send0(input logic [W-1:0] w);
    @(negedge tx_clk);
    while (t0) @(negedge tx_clk);
    d0 = w; s0 = 1; q0.push_back(w); sent0++;
    @(negedge tx_clk);
    d0 = ~w;  // R2: later change must not reach the receiver
    while (!t0) @(negedge tx_clk);
    s0 = 0;
    while (t0) @(negedge tx_clk);
  endtask

  task automatic send1(input logic [W-1:0] w);
    @(negedge tx_clk);
    while (t1) @(negedge tx_clk);
    d1 = w; s1 = 1; q1.push_back(w); sent1++;
    @(negedge tx_clk);
    d1 = w ^ 32'h5A5A_5A5A;  // R2
    while (!t1) @(negedge tx_clk);
    s1 = 0;
    while (t1) @(negedge tx_clk);
  endtask

  function automatic logic [W-1:0] word(input int ph, input int k);
    if (k == 0) return '0;
    if (k == 1) return '1;
    return W'(32'h9E37_79B9 * (k + ph * 50)) ^ W'(k);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge tx_clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int ph = 0; ph < 2; ph++) begin
      rx_half = (ph == 0) ? 13 : 2;
      mon_on = 0;
      tx_rst = 1; rx_rst = 1;
      a1 = 0;
      repeat (4) @(posedge tx_clk);
      repeat (4) @(posedge rx_clk);
      @(negedge tx_clk) tx_rst = 0;
      @(negedge rx_clk) rx_rst = 0;
      chk(t0 == 0 && t1 == 0, "R7", "taken after reset", {t0, t1}, 0);
      chk(k0 == 0 && k1 == 0, "R7", "strobe after reset", {k0, k1}, 0);
      chk(o0 == 0 && o1 == 0, "R7", "data after reset", o0 | o1, 0);
      q0.delete(); q1.delete();
      sent0 = 0; sent1 = 0; got0 = 0; got1 = 0;
      last0 = '0; last1 = '0; pk0 = 0; pk1 = 0; pt0 = 0; pt1 = 0;
      // R6: idle acknowledge has no effect
      a1 = 1;
      for (int i = 0; i < 12; i++) begin
        @(negedge rx_clk);
        chk(!k1 && o1 == 0, "R6", "strobe from idle ack", k1, 0);
      end
      chk(!t1, "R6", "taken from idle ack", t1, 0);
      @(negedge rx_clk) a1 = 0;
      mon_on = 1;
      fork
        for (int k = 0; k < N; k++) send0(word(ph, k));
        for (int k = 0; k < N; k++) send1(word(ph, k) ^ 32'hC3C3_0F0F);
      join
      repeat (60) @(negedge rx_clk);
      chk(q0.size() == 0 && got0 == N, "R1", "count int", got0, N);
      chk(q1.size() == 0 && got1 == N, "R1", "count ext", got1, N);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule